// File: doc/BRIEF.md
# Banked Internal Data Memory Controller

This block holds the 128-byte on-chip data store of a small 8-bit processor core and serves it through four views at once. A byte port reaches any location by its full 8-bit address and reports a miss for the upper half of that address space, which belongs to another register space. A register port reaches eight working registers whose base moves with a 2-bit bank number. A bit port reads or changes one bit of a sixteen-byte window without disturbing the rest of the byte. A stack port uses an 8-bit pointer that increments before it writes and reads before it decrements.

All reads are combinational from the stored words, so an instruction decoder can fetch a register, a bit or the stack top in the same cycle it issues an access. All writes take effect on the rising clock edge. When several ports write the same byte in one cycle, a fixed priority decides which one lands. The pointer can be loaded directly. A range flag shows when the pointer has left the store, and while it is out of range stack writes are dropped.

Top module: `idata_ram_ctrl`

## Requirements
- R1: Byte addresses 00h–7Fh read and write the store. For an address with bit 7 set, `byte_miss` is 1, `byte_rdata` is 00h, and a write changes no stored byte.
- R2: Register n (0–7) in bank k (`bank_sel`, 0–3) is the byte at k*8 + n. So bank 0 is 00h–07h, bank 1 is 08h–0Fh, bank 2 is 10h–17h and bank 3 is 18h–1Fh.
- R3: A register-port write and a byte-port write to the same byte in one cycle store the register-port data.
- R4: Bit address b (0–7Fh) reads bit position b mod 8 of byte 20h + b/8 on `bit_rval`, in the same cycle.
- R5: A bit write sets or clears only the addressed bit, and the other seven bits of that byte keep their values.
- R6: After reset the stack pointer is 07h, `stk_err` is 0 and every stored byte is 00h.
- R7: A push adds one to the stack pointer and writes `stk_wdata` at the new value on the same edge, so the first push after reset lands at 08h.
- R8: `stk_rdata` shows the byte at the current stack pointer, and a pop subtracts one from the pointer on the edge (00h wraps to FFh).
- R9: When push and pop are both asserted, only the push takes effect. A pointer load overrides both, and a push ignored this way writes nothing.
- R10: `stk_err` is 1 exactly while the stack pointer is in 80h–FFh. A push whose new pointer is 80h or above stores nothing, and a read at such a pointer returns 00h.
- R11: For writes to the same byte in one cycle, the priority is register port, then push, then bit port, then byte port. A bit write that wins applies its single-bit change to the old byte value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_addr | input | 8 | Direct or indirect byte address |
| byte_we | input | 1 | Byte write strobe |
| byte_wdata | input | 8 | Byte write data |
| byte_rdata | output | 8 | Byte at `byte_addr`, 00h on a miss |
| byte_miss | output | 1 | `byte_addr` lies outside the store |
| bank_sel | input | 2 | Working register bank number |
| reg_idx | input | 3 | Working register number |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register contents |
| bit_addr | input | 7 | Bit address in the bit window |
| bit_we | input | 1 | Bit write strobe |
| bit_wval | input | 1 | Value written to the bit |
| bit_rval | output | 1 | Current value of the addressed bit |
| push | input | 1 | Pre-increment and store |
| pop | input | 1 | Post-decrement |
| stk_wdata | input | 8 | Data for a push |
| stk_rdata | output | 8 | Byte at the stack pointer |
| sp_ld | input | 1 | Load the stack pointer |
| sp_ld_val | input | 8 | Value for a pointer load |
| sp | output | 8 | Current stack pointer |
| stk_err | output | 1 | Stack pointer outside the store |

## Verification
A wrong stack pointer shows on `sp` on the edge after the push or pop that caused it. It also shows at once on `stk_rdata`, because that read follows the pointer with no delay. A wrong write decode, such as a bank offset error, a bit landing in the wrong position, or an out-of-range address folding back into the low 128 bytes, leaves a wrong byte that the byte port shows in the cycle after the write. For that reason the bench reads back neighbouring and aliased locations, and not only the target. A wrong priority between ports only appears in a cycle where two ports hit the same byte, so those collisions are driven on purpose and the winner's value is read back one edge later.

// File: rtl/idata_pkg.sv
package idata_pkg;

   // Which port supplies the next value of one stored word.
   typedef enum logic [2:0] {
      WSRC_NONE  = 3'd0,
      WSRC_REG   = 3'd1,
      WSRC_STACK = 3'd2,
      WSRC_BIT   = 3'd3,
      WSRC_BYTE  = 3'd4
   } wsrc_e;

   // Fixed write priority: register > stack > bit > byte.
   function automatic wsrc_e pick_src(input logic reg_hit,
                                      input logic stk_hit,
                                      input logic bit_hit,
                                      input logic byte_hit);
      wsrc_e s;
      if (reg_hit)       s = WSRC_REG;
      else if (stk_hit)  s = WSRC_STACK;
      else if (bit_hit)  s = WSRC_BIT;
      else if (byte_hit) s = WSRC_BYTE;
      else               s = WSRC_NONE;
      return s;
   endfunction

endpackage

// File: rtl/idata_addr_decode.sv
module idata_addr_decode #(
   parameter int ADDR_W        = 8,
   parameter int IDX_W         = 7,
   parameter int BANK_W        = 2,
   parameter int RIDX_W        = 3,
   parameter int REGS_PER_BANK = 8,
   parameter int REG_BASE      = 0,
   parameter int BIT_BASE      = 32,
   parameter int BIT_ADDR_W    = 7,
   parameter int POS_W         = 3
) (
   input  logic [ADDR_W-1:0]     byte_addr,
   input  logic [BANK_W-1:0]     bank_sel,
   input  logic [RIDX_W-1:0]     reg_idx,
   input  logic [BIT_ADDR_W-1:0] bit_addr,
   input  logic [ADDR_W-1:0]     sp_cur,
   input  logic [ADDR_W-1:0]     sp_inc,
   output logic [IDX_W-1:0]      byte_word,
   output logic                  byte_in,
   output logic [IDX_W-1:0]      reg_word,
   output logic [IDX_W-1:0]      bit_word,
   output logic [POS_W-1:0]      bit_pos,
   output logic [IDX_W-1:0]      stk_rd_word,
   output logic                  stk_rd_in,
   output logic [IDX_W-1:0]      stk_wr_word,
   output logic                  stk_wr_in
);

   // An address hits the store only when its bits above the word index are clear.
   assign byte_word   = byte_addr[IDX_W-1:0];
   assign byte_in     = (byte_addr[ADDR_W-1:IDX_W] == '0);
   assign stk_rd_word = sp_cur[IDX_W-1:0];
   assign stk_rd_in   = (sp_cur[ADDR_W-1:IDX_W] == '0);
   assign stk_wr_word = sp_inc[IDX_W-1:0];
   assign stk_wr_in   = (sp_inc[ADDR_W-1:IDX_W] == '0);

   // Bank relocation: packed concatenation when the layout allows it,
   // full arithmetic otherwise.
   if (REG_BASE == 0 && (1 << RIDX_W) == REGS_PER_BANK) begin : g_bank_packed
      assign reg_word = IDX_W'({bank_sel, reg_idx});
   end else begin : g_bank_arith
      assign reg_word = IDX_W'(REG_BASE)
                      + IDX_W'(bank_sel) * IDX_W'(REGS_PER_BANK)
                      + IDX_W'(reg_idx);
   end

   // Bit window: upper bits choose the byte, low bits the position.
   assign bit_word = IDX_W'(BIT_BASE) + IDX_W'(bit_addr >> POS_W);
   assign bit_pos  = bit_addr[POS_W-1:0];

endmodule

// File: rtl/idata_stack_ptr.sv
module idata_stack_ptr #(
   parameter int ADDR_W   = 8,
   parameter int IDX_W    = 7,
   parameter int SP_RESET = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic              ld,
   input  logic [ADDR_W-1:0] ld_val,
   output logic [ADDR_W-1:0] sp_q,
   output logic [ADDR_W-1:0] sp_inc,
   output logic              push_act,
   output logic              out_of_range
);

   logic [ADDR_W-1:0] sp_dec;
   logic [ADDR_W-1:0] sp_d;

   assign sp_inc   = sp_q + ADDR_W'(1);
   assign sp_dec   = sp_q - ADDR_W'(1);
   assign push_act = push && !ld;

   // Load beats push, push beats pop.
   always_comb begin
      if (ld)        sp_d = ld_val;
      else if (push) sp_d = sp_inc;
      else if (pop)  sp_d = sp_dec;
      else           sp_d = sp_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sp_q <= ADDR_W'(SP_RESET);
      else        sp_q <= sp_d;
   end

   assign out_of_range = (sp_q[ADDR_W-1:IDX_W] != '0);

endmodule

// File: rtl/idata_word_array.sv
module idata_word_array
   import idata_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int DEPTH          = 128,
   parameter int IDX_W          = 7,
   parameter int POS_W          = 3,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [IDX_W-1:0]  reg_word,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              stk_we,
   input  logic [IDX_W-1:0]  stk_wr_word,
   input  logic [DATA_W-1:0] stk_wdata,
   input  logic              bit_we,
   input  logic [IDX_W-1:0]  bit_word,
   input  logic [POS_W-1:0]  bit_pos,
   input  logic              bit_wval,
   input  logic              byte_we,
   input  logic [IDX_W-1:0]  byte_word,
   input  logic [DATA_W-1:0] byte_wdata,
   input  logic [IDX_W-1:0]  stk_rd_word,
   output logic [DATA_W-1:0] byte_rword,
   output logic [DATA_W-1:0] reg_rword,
   output logic              bit_rval,
   output logic [DATA_W-1:0] stk_rword
);

   logic [DEPTH-1:0][DATA_W-1:0] words;

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      logic [DATA_W-1:0] word_q;
      logic [DATA_W-1:0] word_d;
      wsrc_e             src;

      always_comb begin
         src = pick_src(reg_we  && (reg_word    == IDX_W'(i)),
                        stk_we  && (stk_wr_word == IDX_W'(i)),
                        bit_we  && (bit_word    == IDX_W'(i)),
                        byte_we && (byte_word   == IDX_W'(i)));
         word_d = word_q;
         case (src)
            WSRC_REG:   word_d = reg_wdata;
            WSRC_STACK: word_d = stk_wdata;
            WSRC_BIT:   word_d[bit_pos] = bit_wval;
            WSRC_BYTE:  word_d = byte_wdata;
            default:    word_d = word_q;
         endcase
      end

      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= word_d;
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            word_q <= word_d;
         end
      end

      assign words[i] = word_q;
   end

   assign byte_rword = words[byte_word];
   assign reg_rword  = words[reg_word];
   assign bit_rval   = words[bit_word][bit_pos];
   assign stk_rword  = words[stk_rd_word];

endmodule

// File: rtl/idata_ram_ctrl.sv
module idata_ram_ctrl #(
   parameter int DATA_W         = 8,
   parameter int ADDR_W         = 8,
   parameter int DEPTH          = 128,
   parameter int NUM_BANKS      = 4,
   parameter int REGS_PER_BANK  = 8,
   parameter int REG_BASE       = 0,
   parameter int BIT_BASE       = 32,
   parameter int BIT_BYTES      = 16,
   parameter int SP_RESET       = 7,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int IDX_W         = $clog2(DEPTH),
   localparam int BANK_W        = $clog2(NUM_BANKS),
   localparam int RIDX_W        = $clog2(REGS_PER_BANK),
   localparam int POS_W         = $clog2(DATA_W),
   localparam int BIT_ADDR_W    = $clog2(BIT_BYTES * DATA_W)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     byte_addr,
   input  logic                  byte_we,
   input  logic [DATA_W-1:0]     byte_wdata,
   output logic [DATA_W-1:0]     byte_rdata,
   output logic                  byte_miss,
   input  logic [BANK_W-1:0]     bank_sel,
   input  logic [RIDX_W-1:0]     reg_idx,
   input  logic                  reg_we,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   input  logic [BIT_ADDR_W-1:0] bit_addr,
   input  logic                  bit_we,
   input  logic                  bit_wval,
   output logic                  bit_rval,
   input  logic                  push,
   input  logic                  pop,
   input  logic [DATA_W-1:0]     stk_wdata,
   output logic [DATA_W-1:0]     stk_rdata,
   input  logic                  sp_ld,
   input  logic [ADDR_W-1:0]     sp_ld_val,
   output logic [ADDR_W-1:0]     sp,
   output logic                  stk_err
);

   // Elaboration-time parameter checks.
   if ((1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two");
   end
   if (IDX_W >= ADDR_W) begin : g_bad_addr
      $error("address must be wider than the word index");
   end
   if ((1 << POS_W) != DATA_W) begin : g_bad_width
      $error("DATA_W must be a power of two");
   end
   if (REG_BASE + NUM_BANKS * REGS_PER_BANK > BIT_BASE) begin : g_bad_banks
      $error("register banks overlap the bit window");
   end
   if (BIT_BASE + BIT_BYTES > DEPTH) begin : g_bad_bits
      $error("bit window exceeds the store");
   end

   logic [IDX_W-1:0]  byte_word, reg_word, bit_word, stk_rd_word, stk_wr_word;
   logic [POS_W-1:0]  bit_pos;
   logic              byte_in, stk_rd_in, stk_wr_in;
   logic [ADDR_W-1:0] sp_inc;
   logic              push_act;
   logic [DATA_W-1:0] byte_rword, reg_rword, stk_rword;

   idata_stack_ptr #(
      .ADDR_W  (ADDR_W),
      .IDX_W   (IDX_W),
      .SP_RESET(SP_RESET)
   ) u_sp (
      .clk         (clk),
      .rst_n       (rst_n),
      .push        (push),
      .pop         (pop),
      .ld          (sp_ld),
      .ld_val      (sp_ld_val),
      .sp_q        (sp),
      .sp_inc      (sp_inc),
      .push_act    (push_act),
      .out_of_range(stk_err)
   );

   idata_addr_decode #(
      .ADDR_W       (ADDR_W),
      .IDX_W        (IDX_W),
      .BANK_W       (BANK_W),
      .RIDX_W       (RIDX_W),
      .REGS_PER_BANK(REGS_PER_BANK),
      .REG_BASE     (REG_BASE),
      .BIT_BASE     (BIT_BASE),
      .BIT_ADDR_W   (BIT_ADDR_W),
      .POS_W        (POS_W)
   ) u_dec (
      .byte_addr  (byte_addr),
      .bank_sel   (bank_sel),
      .reg_idx    (reg_idx),
      .bit_addr   (bit_addr),
      .sp_cur     (sp),
      .sp_inc     (sp_inc),
      .byte_word  (byte_word),
      .byte_in    (byte_in),
      .reg_word   (reg_word),
      .bit_word   (bit_word),
      .bit_pos    (bit_pos),
      .stk_rd_word(stk_rd_word),
      .stk_rd_in  (stk_rd_in),
      .stk_wr_word(stk_wr_word),
      .stk_wr_in  (stk_wr_in)
   );

   idata_word_array #(
      .DATA_W        (DATA_W),
      .DEPTH         (DEPTH),
      .IDX_W         (IDX_W),
      .POS_W         (POS_W),
      .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) u_mem (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_we     (reg_we),
      .reg_word   (reg_word),
      .reg_wdata  (reg_wdata),
      .stk_we     (push_act && stk_wr_in),
      .stk_wr_word(stk_wr_word),
      .stk_wdata  (stk_wdata),
      .bit_we     (bit_we),
      .bit_word   (bit_word),
      .bit_pos    (bit_pos),
      .bit_wval   (bit_wval),
      .byte_we    (byte_we && byte_in),
      .byte_word  (byte_word),
      .byte_wdata (byte_wdata),
      .stk_rd_word(stk_rd_word),
      .byte_rword (byte_rword),
      .reg_rword  (reg_rword),
      .bit_rval   (bit_rval),
      .stk_rword  (stk_rword)
   );

   assign byte_miss  = !byte_in;
   assign byte_rdata = byte_in   ? byte_rword : '0;
   assign stk_rdata  = stk_rd_in ? stk_rword  : '0;
   assign reg_rdata  = reg_rword;

endmodule

// File: rtl/idata_ram_ctrl_chk.sv
module idata_ram_ctrl_chk #(
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 8,
   parameter int BANK_W     = 2,
   parameter int RIDX_W     = 3,
   parameter int BIT_ADDR_W = 7,
   parameter int SP_RESET   = 7
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [ADDR_W-1:0]     sp,
   input logic                  stk_err,
   input logic                  push,
   input logic                  pop,
   input logic                  sp_ld,
   input logic                  byte_miss,
   input logic [DATA_W-1:0]     byte_rdata,
   input logic                  reg_we,
   input logic [DATA_W-1:0]     reg_wdata,
   input logic [DATA_W-1:0]     reg_rdata,
   input logic [BANK_W-1:0]     bank_sel,
   input logic [RIDX_W-1:0]     reg_idx,
   input logic                  bit_we,
   input logic [BIT_ADDR_W-1:0] bit_addr,
   input logic                  bit_wval,
   input logic                  bit_rval
);

   logic seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= 1'b1;
   end

   // R6: first edge after reset still shows the reset pointer
   a_r6_sp_reset: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_q |-> (sp == ADDR_W'(SP_RESET) && !stk_err));

   a_r7_push_incr: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !sp_ld) |=> (sp == $past(sp) + ADDR_W'(1)));

   a_r8_pop_decr: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !sp_ld) |=> (sp == $past(sp) - ADDR_W'(1)));

   a_r10_err_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !sp_ld && sp == ADDR_W'(8'h7F)) |=> stk_err);

   a_r1_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      byte_miss |-> (byte_rdata == '0));

   a_r3_reg_wins: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we ##1 (bank_sel == $past(bank_sel) && reg_idx == $past(reg_idx))
      |-> (reg_rdata == $past(reg_wdata)));

   a_r5_bit_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_we && !push) ##1 (bit_addr == $past(bit_addr))
      |-> (bit_rval == $past(bit_wval)));

endmodule

bind idata_ram_ctrl idata_ram_ctrl_chk #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .BANK_W    (BANK_W),
   .RIDX_W    (RIDX_W),
   .BIT_ADDR_W(BIT_ADDR_W),
   .SP_RESET  (SP_RESET)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sp        (sp),
   .stk_err   (stk_err),
   .push      (push),
   .pop       (pop),
   .sp_ld     (sp_ld),
   .byte_miss (byte_miss),
   .byte_rdata(byte_rdata),
   .reg_we    (reg_we),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .bank_sel  (bank_sel),
   .reg_idx   (reg_idx),
   .bit_we    (bit_we),
   .bit_addr  (bit_addr),
   .bit_wval  (bit_wval),
   .bit_rval  (bit_rval)
);

// File: tb/idata_ram_ctrl_bench.sv
`timescale 1ns/1ps
module idata_ram_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] byte_addr = '0;
   logic       byte_we = 1'b0;
   logic [7:0] byte_wdata = '0;
   logic [7:0] byte_rdata;
   logic       byte_miss;
   logic [1:0] bank_sel = '0;
   logic [2:0] reg_idx = '0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [6:0] bit_addr = '0;
   logic       bit_we = 1'b0;
   logic       bit_wval = 1'b0;
   logic       bit_rval;
   logic       push = 1'b0;
   logic       pop = 1'b0;
   logic [7:0] stk_wdata = '0;
   logic [7:0] stk_rdata;
   logic       sp_ld = 1'b0;
   logic [7:0] sp_ld_val = '0;
   logic [7:0] sp;
   logic       stk_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   idata_ram_ctrl u_idata_ram_ctrl (
      .clk(clk), .rst_n(rst_n),
      .byte_addr(byte_addr), .byte_we(byte_we), .byte_wdata(byte_wdata),
      .byte_rdata(byte_rdata), .byte_miss(byte_miss),
      .bank_sel(bank_sel), .reg_idx(reg_idx), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .bit_addr(bit_addr), .bit_we(bit_we), .bit_wval(bit_wval), .bit_rval(bit_rval),
      .push(push), .pop(pop), .stk_wdata(stk_wdata), .stk_rdata(stk_rdata),
      .sp_ld(sp_ld), .sp_ld_val(sp_ld_val), .sp(sp), .stk_err(stk_err)
   );

   // Vector: {op, addr, data, expected}
   // op 0 byte write+readback, 1 register write (addr[4:3] bank, addr[2:0] reg)
   // then byte readback, 2 bit write then byte readback at 20h+addr/8,
   // 3 bit read, 4 byte read.
   localparam int NVEC = 16;
   localparam logic [27:0] VEC [NVEC] = '{
      {4'd0, 8'h30, 8'hA5, 8'hA5},
      {4'd0, 8'h7F, 8'h3C, 8'h3C},
      {4'd0, 8'h80, 8'hEE, 8'h00},
      {4'd4, 8'h00, 8'h00, 8'h00},
      {4'd1, 8'h15, 8'h11, 8'h11},
      {4'd1, 8'h00, 8'h22, 8'h22},
      {4'd1, 8'h1F, 8'h33, 8'h33},
      {4'd2, 8'h00, 8'h01, 8'h01},
      {4'd2, 8'h07, 8'h01, 8'h81},
      {4'd2, 8'h00, 8'h00, 8'h80},
      {4'd2, 8'h7F, 8'h01, 8'h80},
      {4'd2, 8'h4B, 8'h01, 8'h08},
      {4'd3, 8'h4B, 8'h00, 8'h01},
      {4'd3, 8'h4A, 8'h00, 8'h00},
      {4'd3, 8'h07, 8'h00, 8'h01},
      {4'd4, 8'h7F, 8'h00, 8'h3C}
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      byte_we = 1'b0; reg_we = 1'b0; bit_we = 1'b0;
      push = 1'b0; pop = 1'b0; sp_ld = 1'b0;
   endtask

   task automatic rd_byte(input string tag, input logic [7:0] a, input logic [7:0] exp);
      byte_addr = a;
      #1;
      chk(tag, byte_rdata, exp);
   endtask

   task automatic load_sp(input logic [7:0] v);
      sp_ld = 1'b1; sp_ld_val = v;
      tick();
      idle();
   endtask

   initial begin
      #1000000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R6 reset state
      chk("R6 sp after reset", sp, 8'h07);
      chk("R6 stk_err after reset", {7'd0, stk_err}, 8'h00);
      rd_byte("R6 byte 30h cleared", 8'h30, 8'h00);
      chk("R6 bank0 R0 cleared", reg_rdata, 8'h00);

      // Table walk
      for (int i = 0; i < NVEC; i++) begin
         logic [3:0] op;
         logic [7:0] a, d, e;
         {op, a, d, e} = VEC[i];
         case (op)
            4'd0: begin
               byte_addr = a; byte_wdata = d; byte_we = 1'b1;
               tick(); idle();
               rd_byte("R1 byte write readback", a, e);
            end
            4'd1: begin
               bank_sel = a[4:3]; reg_idx = a[2:0]; reg_wdata = d; reg_we = 1'b1;
               tick(); idle();
               rd_byte("R2 bank register lands at bank*8+n", a, e);
            end
            4'd2: begin
               bit_addr = a[6:0]; bit_wval = d[0]; bit_we = 1'b1;
               tick(); idle();
               rd_byte("R5 bit write changes one bit", 8'h20 + (a >> 3), e);
            end
            4'd3: begin
               bit_addr = a[6:0];
               #1;
               chk("R4 bit read position", {7'd0, bit_rval}, e);
            end
            default: begin
               rd_byte("R1 byte read", a, e);
            end
         endcase
      end

      // R7 push
      push = 1'b1; stk_wdata = 8'h5A;
      tick(); idle();
      #1;
      chk("R7 sp after first push", sp, 8'h08);
      rd_byte("R7 first push lands at 08h", 8'h08, 8'h5A);
      push = 1'b1; stk_wdata = 8'h6B;
      tick(); idle();
      #1;
      chk("R7 sp after second push", sp, 8'h09);
      rd_byte("R7 second push at 09h", 8'h09, 8'h6B);

      // R8 pop
      chk("R8 stack top before pop", stk_rdata, 8'h6B);
      pop = 1'b1;
      tick(); idle();
      #1;
      chk("R8 sp after pop", sp, 8'h08);
      chk("R8 stack top after pop", stk_rdata, 8'h5A);

      // R3 register port beats byte port at 0Ah
      bank_sel = 2'd1; reg_idx = 3'd2; reg_wdata = 8'hC1; reg_we = 1'b1;
      byte_addr = 8'h0A; byte_wdata = 8'hD2; byte_we = 1'b1;
      tick(); idle();
      rd_byte("R3 register port wins", 8'h0A, 8'hC1);
      reg_idx = 3'd0;
      #1;
      chk("R2 bank1 R0 aliases 08h", reg_rdata, 8'h5A);

      // R9 push and pop together, and load over push
      load_sp(8'h40);
      push = 1'b1; pop = 1'b1; stk_wdata = 8'h77;
      tick(); idle();
      #1;
      chk("R9 push wins over pop", sp, 8'h41);
      rd_byte("R9 push data stored", 8'h41, 8'h77);
      sp_ld = 1'b1; sp_ld_val = 8'h50; push = 1'b1; stk_wdata = 8'h12;
      tick(); idle();
      #1;
      chk("R9 load overrides push", sp, 8'h50);
      rd_byte("R9 overridden push writes nothing", 8'h51, 8'h00);

      // R11 priority collisions
      load_sp(8'h1F);
      push = 1'b1; stk_wdata = 8'hF0;
      bit_addr = 7'h00; bit_wval = 1'b1; bit_we = 1'b1;
      tick(); idle();
      rd_byte("R11 push beats bit write", 8'h20, 8'hF0);
      bit_addr = 7'h4B; bit_wval = 1'b0; bit_we = 1'b1;
      byte_addr = 8'h29; byte_wdata = 8'hFF; byte_we = 1'b1;
      tick(); idle();
      rd_byte("R11 bit write beats byte write", 8'h29, 8'h00);

      // R10 overflow past 7Fh
      load_sp(8'h7F);
      push = 1'b1; stk_wdata = 8'h99;
      tick(); idle();
      #1;
      chk("R10 sp wraps to 80h", sp, 8'h80);
      chk("R10 stk_err raised", {7'd0, stk_err}, 8'h01);
      rd_byte("R10 no fold into 00h", 8'h00, 8'h22);
      rd_byte("R10 7Fh untouched", 8'h7F, 8'h3C);
      byte_addr = 8'h80;
      #1;
      chk("R1 byte_miss at 80h", {7'd0, byte_miss}, 8'h01);
      chk("R10 stack read out of range", stk_rdata, 8'h00);
      pop = 1'b1;
      tick(); idle();
      #1;
      chk("R10 err clears back in range", {7'd0, stk_err}, 8'h00);
      chk("R8 stack top at 7Fh", stk_rdata, 8'h3C);

      // R10 underflow below 00h
      load_sp(8'h00);
      pop = 1'b1;
      tick(); idle();
      #1;
      chk("R8 pop wraps 00h to FFh", sp, 8'hFF);
      chk("R10 stk_err at FFh", {7'd0, stk_err}, 8'h01);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule